// File: doc/BRIEF.md
# Slow-Edge Clock Enable Recovery

This block lives wholly in a fast clock domain. It produces single-cycle enable pulses that are phase-locked to a related slow clock running at one quarter of the fast rate. Only one signal crosses from the slow domain: a level that a slow-domain flop inverts on every slow edge. The block passes that level through a short synchronizer. It compares the synchronizer output with its own value one cycle earlier. A mismatch marks one slow edge.

Two enables come out. The data-valid enable fires once for each detected slow edge, so downstream logic can take the data the slow domain has just produced. The early enable comes from a small phase counter that the edge pulse reloads. It fires in the last fast cycle before the next slow edge, which lets the fast logic drive I/O that the slow domain will sample. No derived clock is made; every consumer stays on the fast clock and is gated by these enables.

Phase acquisition is reported on a lock output. An edge that arrives out of step with the counter, or an expected edge that does not arrive, raises a sticky phase error.

Top module: `ce_edge_enable_gen`

## Requirements
- R1: While rst_ni is low, valid_en_o, early_en_o, locked_o and phase_error_o are all 0.
- R2: A change of slow_tgl_i, in either direction, that is driven just after fast edge n is detected as a slow edge in the fast cycle that follows edge n+SYNC_STAGES (n+2 by default).
- R3: Once locked, valid_en_o is 1 for exactly the cycles in which a slow edge is detected, and is 0 in all other cycles.
- R4: Once locked, early_en_o is 1 in the cycle after each detected edge and then every RATIO cycles, so that it falls in the last fast cycle before the next slow edge.
- R5: locked_o rises in the cycle after the first detected edge and holds until reset. That first edge gives no valid_en_o pulse. Both enables stay 0 while locked_o is 0.
- R6: For the first SYNC_STAGES+1 fast cycles after reset, edge detection is masked, so a slow_tgl_i level of 1 present at reset is not taken as an edge.
- R7: A detected edge that arrives while locked, at a counter phase other than the expected one, sets phase_error_o in the next cycle. The same edge re-aligns early_en_o so that it fires in the cycle after that edge.
- R8: If no edge is detected while locked in a cycle where one is expected, phase_error_o is set in the next cycle. early_en_o keeps its RATIO-cycle cadence.
- R9: phase_error_o is sticky until reset. A constant slow_tgl_i never sets locked_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tgl_i | input | 1 | Level inverted on every slow clock edge (slow domain) |
| valid_en_o | output | 1 | One-cycle pulse after each detected slow edge |
| early_en_o | output | 1 | One-cycle pulse in the last fast cycle before a slow edge |
| locked_o | output | 1 | Phase has been acquired |
| phase_error_o | output | 1 | Sticky: an edge was out of step or missing |

## Verification
The bench builds the block with its defaults: RATIO of 4 and SYNC_STAGES of 2. With these values the early enable lands one counter step after the edge pulse. Every starting phase of the slow edge against the fast clock can be reached with only four offsets, and the bench covers them all with random initial toggle levels. Directed runs shift the slow phase by one cycle in each direction, drop a single slow edge, and hold the toggle constant. These drive the counter through every resynchronisation and error path.

// File: rtl/ce_pkg.sv
package ce_pkg;
  // counter value (0 = edge cycle) of the last fast cycle before the next slow edge
  function automatic int unsigned early_slot(int unsigned ratio, int unsigned lat);
    return (2 * ratio - 1 - (lat % ratio)) % ratio;
  endfunction
endpackage

// File: rtl/ce_tgl_sync.sv
module ce_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic pulse_o
);
  localparam int unsigned AW = $clog2(STAGES + 1);

  logic [STAGES-1:0] stage;
  logic              prev_q;
  logic [AW-1:0]     arm_cnt_q;
  logic              armed_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b0;
        else         q <= tgl_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b0;
        else         q <= stage[i-1];
    end
    assign stage[i] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stage[STAGES-1];

  // hold detection off until prev_q carries a real sample
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      arm_cnt_q <= '0;
      armed_q   <= 1'b0;
    end else if (!armed_q) begin
      if (arm_cnt_q == AW'(STAGES)) armed_q <= 1'b1;
      else                          arm_cnt_q <= arm_cnt_q + 1'b1;
    end

  assign pulse_o = armed_q & (stage[STAGES-1] ^ prev_q);
endmodule

// File: rtl/ce_phase_track.sv
module ce_phase_track #(
  parameter int unsigned RATIO = 4,
  parameter int unsigned EARLY = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic valid_o,
  output logic early_o,
  output logic locked_o,
  output logic error_o
);
  localparam int unsigned   CW     = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(1 % RATIO);
  localparam logic [CW-1:0] LAST   = CW'(RATIO - 1);
  localparam logic [CW-1:0] E_CNT  = CW'(EARLY);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          locked_q, err_q;
  logic          mismatch;

  always_comb begin
    if (pulse_i)            cnt_d = RELOAD;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  // edge off-slot, or expected slot without edge
  assign mismatch = locked_q & (pulse_i ^ (cnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      locked_q <= locked_q | pulse_i;
      err_q    <= err_q | mismatch;
    end

  assign valid_o  = pulse_i & locked_q;
  assign early_o  = locked_q & (cnt_q == E_CNT);
  assign locked_o = locked_q;
  assign error_o  = err_q;
endmodule

// File: rtl/ce_edge_enable_gen.sv
module ce_edge_enable_gen #(
  parameter int unsigned RATIO       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_tgl_i,
  output logic valid_en_o,
  output logic early_en_o,
  output logic locked_o,
  output logic phase_error_o
);
  localparam int unsigned EARLY = ce_pkg::early_slot(RATIO, SYNC_STAGES);

  logic edge_pulse;

  ce_tgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgl_i   (slow_tgl_i),
    .pulse_o (edge_pulse)
  );

  ce_phase_track #(.RATIO(RATIO), .EARLY(EARLY)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (edge_pulse),
    .valid_o  (valid_en_o),
    .early_o  (early_en_o),
    .locked_o (locked_o),
    .error_o  (phase_error_o)
  );
endmodule

// File: rtl/ce_edge_enable_gen_chk.sv
module ce_edge_enable_gen_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pulse_i,
  input logic valid_en_i,
  input logic early_en_i,
  input logic locked_i,
  input logic phase_error_i
);
  assert_quiet_unlocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> (!valid_en_i && !early_en_i));

  assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> locked_i);

  assert_lock_from_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_i) |-> $past(pulse_i));

  assert_valid_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_en_i |-> pulse_i);

  assert_early_after_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_en_i |=> early_en_i);

  assert_early_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (early_en_i && !pulse_i) |=> !early_en_i);

  assert_error_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_error_i |=> phase_error_i);

  assert_error_needs_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_error_i) |-> $past(locked_i));
endmodule

bind ce_edge_enable_gen ce_edge_enable_gen_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pulse_i       (edge_pulse),
  .valid_en_i    (valid_en_o),
  .early_en_i    (early_en_o),
  .locked_i      (locked_o),
  .phase_error_i (phase_error_o)
);

// File: tb/ce_edge_enable_gen_test.sv
module ce_edge_enable_gen_test;
  localparam int RATIO = 4;
  localparam int LAT   = 2;
  localparam int MAXC  = 160;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tgl = 1'b0;
  logic valid_en, early_en, locked, phase_err;

  int checks = 0;
  int errors = 0;
  bit flip_at [0:MAXC];

  always #2 clk = ~clk;

  ce_edge_enable_gen #(.RATIO(RATIO), .SYNC_STAGES(LAT)) uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .slow_tgl_i    (tgl),
    .valid_en_o    (valid_en),
    .early_en_o    (early_en),
    .locked_o      (locked),
    .phase_error_o (phase_err)
  );

  task automatic check(string tag, string what, logic act, logic exp, int cyc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", tag, what, cyc, act, exp);
    end
  endtask

  function automatic bit exp_edge(int m);
    return (m >= LAT) && flip_at[m-LAT];
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic clear_sched();
    for (int i = 0; i <= MAXC; i++) flip_at[i] = 1'b0;
  endtask

  // flips every RATIO edges from first; shift added after nflips; skip one flip
  task automatic make_sched(int first, int nflips, int shift, int skip_idx, int last);
    int e;
    int k;
    clear_sched();
    e = first;
    k = 0;
    while (e <= last) begin
      if (k != skip_idx) flip_at[e] = 1'b1;
      k++;
      e += RATIO;
      if (k == nflips) e += shift;
    end
  endtask

  task automatic run_case(string tag, logic init, int ncyc);
    bit seen;
    bit err;
    int ref_c;
    int ph;
    bit pe;
    rst_ni = 1'b0;
    tgl = init;
    repeat (3) @(negedge clk);
    check("R1", "valid", valid_en, 1'b0, 0);
    check("R1", "early", early_en, 1'b0, 0);
    check("R1", "locked", locked, 1'b0, 0);
    check("R1", "error", phase_err, 1'b0, 0);
    rst_ni = 1'b1;
    seen = 0; err = 0; ref_c = 0;
    for (int m = 1; m <= ncyc; m++) begin
      @(posedge clk);
      #1;
      if (flip_at[m]) tgl = ~tgl;
      @(negedge clk);
      pe = exp_edge(m);
      ph = seen ? ((m - ref_c) % RATIO) : 0;
      check(tag, "R2 R3 valid", valid_en, pe & seen, m);
      check(tag, "R4 early", early_en, seen & (ph == 1), m);
      check(tag, (m <= LAT + 1) ? "R6 locked" : "R5 locked", locked, seen, m);
      check(tag, "R7 R8 error", phase_err, err, m);
      if (seen && (pe != (ph == 0))) err = 1;
      if (pe) begin
        seen = 1;
        ref_c = m;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd4242);
    // every starting phase, both initial levels, random lengths
    for (int r = 0; r < 12; r++) begin
      int first;
      logic lvl;
      first = 1 + int'($urandom % RATIO);
      lvl = logic'($urandom % 2);
      make_sched(first, 1000, 0, -1, 120);
      run_case("R2 R3 R4 random", lvl, 90 + int'($urandom % 30));
    end
    for (int p = 1; p <= RATIO; p++) begin
      make_sched(p, 1000, 0, -1, 120);
      run_case("R4 phase sweep", 1'b1, 60);
    end
    make_sched(2, 6, 1, -1, 120);
    run_case("R7 late shift", 1'b0, 100);
    make_sched(3, 5, -1, -1, 120);
    run_case("R7 early shift", 1'b1, 100);
    make_sched(1, 1000, 0, 7, 120);
    run_case("R8 missing edge", 1'b0, 100);
    clear_sched();
    run_case("R9 constant high", 1'b1, 40);
    run_case("R9 constant low", 1'b0, 40);
    summary();
  end
endmodule